// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope analog-to-digital converter. It drives a two-bit phase code to an external integrating front end and watches a single comparator bit that comes back. One conversion has four phases. The block first nulls offsets (auto-zero). It then integrates the input for a fixed number of clocks. Next it ramps the integrator back with the reference and times how long that takes. Finally it drains leftover charge (integrator zero). The timed ramp-down gives the magnitude of the result. The comparator level sampled at the end of integration gives its sign.

A conversion starts on a one-cycle start pulse, or starts again by itself for as long as the continuous input is held high. The phase lengths and the two timeout limits come in as plain inputs. The result appears as a sign bit, an unsigned count and an overrange flag, all held until the next result and marked by a one-cycle valid pulse. A separate one-cycle flag reports an integrator-zero phase that ran out of time.

The controller has five states. HOLD is idle in auto-zero and waits for a request. AZ is a timed auto-zero before integration. INT is signal integration. DEINT is reference de-integration. IZ is integrator zero. The transitions are:
- HOLD→AZ on start or continuous.
- AZ→INT when the auto-zero count expires.
- INT→DEINT when the integration count expires.
- DEINT→IZ on the comparator's falling edge or on timeout.
- IZ→HOLD when the comparator reads high or on timeout.

Top module: `dslope_seq`

## Requirements
- R1: The phase code on `ab_o` is 01 in HOLD and AZ, 10 in INT, 11 in DEINT and 00 in IZ. The phases follow each other only in the order AZ, INT, DEINT, IZ, then back to auto-zero.
- R2: INT lasts exactly `int_len_i` clock cycles (value at least 1).
- R3: AZ lasts `az_len_i` cycles. When `az_len_i` is 0, it lasts `int_len_i` cycles instead.
- R4: On the last INT cycle the synchronized comparator level is captured as the sign. 1 means a positive input, 0 a negative one. The sign is reported in `res_sign_o`.
- R5: The comparator passes through a two-flop synchronizer. In DEINT, the first cycle that sees a synchronized high-to-low edge ends the phase. `res_mag_o` is loaded with the number of DEINT cycles before that cycle, `res_ovr_o` is cleared, and `res_valid_o` pulses high for one cycle, which is the first IZ cycle.
- R6: If no falling edge is seen within `deint_max_i` DEINT cycles, the phase ends. The result is then reported with `res_mag_o` = `deint_max_i` and `res_ovr_o` = 1, and IZ follows.
- R7: IZ holds while the synchronized comparator is low. The first IZ cycle that sees it high moves the block to HOLD.
- R8: If IZ has lasted `iz_max_i` cycles without the comparator going high, the block goes to HOLD and `iz_tmo_o` pulses high for one cycle.
- R9: The comparator is ignored in HOLD and AZ. Toggling it there changes neither the phase timing nor the result.
- R10: `start_i` is ignored outside HOLD. While `cont_i` is high, HOLD moves straight to AZ, so conversions run back to back.
- R11: During reset `ab_o` is 01, `res_valid_o`, `res_sign_o`, `res_ovr_o` and `iz_tmo_o` are 0, and `res_mag_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period is one count |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle conversion request |
| cont_i | input | 1 | Continuous conversion request |
| az_len_i | input | CW | Auto-zero length in cycles, 0 selects the integration length |
| int_len_i | input | CW | Integration length in cycles |
| deint_max_i | input | CW | De-integration timeout in cycles |
| iz_max_i | input | CW | Integrator-zero timeout in cycles |
| cmp_i | input | 1 | Asynchronous comparator bit |
| ab_o | output | 2 | Phase code to the front end |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_sign_o | output | 1 | Result sign, 1 positive |
| res_mag_o | output | CW | Result magnitude in counts |
| res_ovr_o | output | 1 | Result came from a de-integration timeout |
| iz_tmo_o | output | 1 | One-cycle integrator-zero timeout flag |

## Verification
The hardest case to reach is the exact boundary between the comparator edge and the timeouts. It has to be set up through the comparator pin while the two synchronizer stages delay every change by two cycles. The stimulus watches `ab_o` at each falling clock edge and moves the comparator a chosen number of cycles after DEINT begins. This gives known magnitudes, including a negative conversion in which the comparator must first rise inside DEINT before it can fall. Separate runs hold the comparator level so that each timeout fires. Throughout all of this, a behavioural model compares every output on every clock.

// File: rtl/dslope_pkg.sv
package dslope_pkg;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_AZ,
        ST_INT,
        ST_DEINT,
        ST_IZ
    } seq_st_t;

    localparam logic [1:0] AB_AZ    = 2'b01;
    localparam logic [1:0] AB_INT   = 2'b10;
    localparam logic [1:0] AB_DEINT = 2'b11;
    localparam logic [1:0] AB_IZ    = 2'b00;

endpackage

// File: rtl/dslope_sync.sv
module dslope_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic lvl_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign lvl_o  = chain_q[STAGES-1];
    assign fall_o = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/dslope_cnt.sv
module dslope_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic [W-1:0] lim_i,
    output logic [W-1:0] cnt_o,
    output logic         last_o
);
    localparam logic [W-1:0] CNT_TOP = '1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (clr_i)          cnt_q <= '0;
        else if (cnt_q != CNT_TOP) cnt_q <= cnt_q + W'(1);
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q == lim_i - W'(1));
endmodule

// File: rtl/dslope_result.sv
module dslope_result #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         sign_i,
    input  logic [W-1:0] mag_i,
    input  logic         ovr_i,
    output logic         valid_o,
    output logic         sign_o,
    output logic [W-1:0] mag_o,
    output logic         ovr_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            sign_o  <= 1'b0;
            mag_o   <= '0;
            ovr_o   <= 1'b0;
        end else begin
            valid_o <= load_i;
            if (load_i) begin
                sign_o <= sign_i;
                mag_o  <= mag_i;
                ovr_o  <= ovr_i;
            end
        end
    end
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
    import dslope_pkg::*;
#(
    parameter int CW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          cont_i,
    input  logic [CW-1:0] az_len_i,
    input  logic [CW-1:0] int_len_i,
    input  logic [CW-1:0] deint_max_i,
    input  logic [CW-1:0] iz_max_i,
    input  logic          cmp_i,
    output logic [1:0]    ab_o,
    output logic          res_valid_o,
    output logic          res_sign_o,
    output logic [CW-1:0] res_mag_o,
    output logic          res_ovr_o,
    output logic          iz_tmo_o
);
    seq_st_t       st_q, st_d;
    logic          cmp_lvl, cmp_fall;
    logic [CW-1:0] az_eff, lim, cnt;
    logic          cnt_last, cnt_clr;
    logic          sign_q, tmo_q;
    logic          ld, ld_ovr;
    logic [CW-1:0] ld_mag;

    dslope_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(cmp_i),
        .lvl_o  (cmp_lvl),
        .fall_o (cmp_fall)
    );

    // A zero auto-zero length borrows the integration length.
    assign az_eff = (az_len_i == '0) ? int_len_i : az_len_i;

    always_comb begin
        case (st_q)
            ST_AZ:    lim = az_eff;
            ST_DEINT: lim = deint_max_i;
            ST_IZ:    lim = iz_max_i;
            default:  lim = int_len_i;
        endcase
    end

    assign cnt_clr = (st_d != st_q);

    dslope_cnt #(.W(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (cnt_clr),
        .lim_i (lim),
        .cnt_o (cnt),
        .last_o(cnt_last)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_HOLD:  if (start_i || cont_i)    st_d = ST_AZ;
            ST_AZ:    if (cnt_last)             st_d = ST_INT;
            ST_INT:   if (cnt_last)             st_d = ST_DEINT;
            ST_DEINT: if (cmp_fall || cnt_last) st_d = ST_IZ;
            ST_IZ:    if (cmp_lvl || cnt_last)  st_d = ST_HOLD;
            default:                            st_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_HOLD;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sign_q <= 1'b0;
            tmo_q  <= 1'b0;
        end else begin
            if (st_q == ST_INT && cnt_last) sign_q <= cmp_lvl;
            tmo_q <= (st_q == ST_IZ) && !cmp_lvl && cnt_last;
        end
    end

    assign ld     = (st_q == ST_DEINT) && (cmp_fall || cnt_last);
    assign ld_mag = cmp_fall ? cnt : deint_max_i;
    assign ld_ovr = !cmp_fall;

    dslope_result #(.W(CW)) u_res (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (ld),
        .sign_i (sign_q),
        .mag_i  (ld_mag),
        .ovr_i  (ld_ovr),
        .valid_o(res_valid_o),
        .sign_o (res_sign_o),
        .mag_o  (res_mag_o),
        .ovr_o  (res_ovr_o)
    );

    assign iz_tmo_o = tmo_q;

    always_comb begin
        unique case (st_q)
            ST_INT:   ab_o = AB_INT;
            ST_DEINT: ab_o = AB_DEINT;
            ST_IZ:    ab_o = AB_IZ;
            default:  ab_o = AB_AZ;
        endcase
    end

    // R1
    int_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_o == AB_INT) |=> (ab_o == AB_INT || ab_o == AB_DEINT));
    // R1
    deint_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_o == AB_DEINT) |=> (ab_o == AB_DEINT || ab_o == AB_IZ));
    // R1
    iz_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ab_o == AB_IZ) |=> (ab_o == AB_IZ || ab_o == AB_AZ));
    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |=> !res_valid_o);
    // R5
    valid_in_iz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> (ab_o == AB_IZ));
    // R6
    ovr_mag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid_o && res_ovr_o) |-> (res_mag_o == $past(deint_max_i)));
    // R8
    tmo_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iz_tmo_o |-> (ab_o == AB_AZ && $past(ab_o == AB_IZ)));
endmodule

// File: tb/dslope_seq_tb.sv
module dslope_seq_tb;
    localparam int CLK_NS = 10;
    localparam int CW     = 16;

    logic          clk = 1'b0, rst_n = 1'b0, start = 1'b0, cont = 1'b0, cmp = 1'b0;
    logic [CW-1:0] az_len = 16'd4, int_len = 16'd8, dmax = 16'd100, izmax = 16'd50;
    logic [1:0]    ab_o;
    logic          res_valid_o, res_sign_o, res_ovr_o, iz_tmo_o;
    logic [CW-1:0] res_mag_o;

    dslope_seq #(.CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .cont_i(cont),
        .az_len_i(az_len), .int_len_i(int_len), .deint_max_i(dmax), .iz_max_i(izmax),
        .cmp_i(cmp), .ab_o(ab_o), .res_valid_o(res_valid_o), .res_sign_o(res_sign_o),
        .res_mag_o(res_mag_o), .res_ovr_o(res_ovr_o), .iz_tmo_o(iz_tmo_o)
    );

    always #(CLK_NS/2) clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Behavioural reference: 0 hold, 1 auto-zero, 2 integrate, 3 de-integrate, 4 zero
    int m_st, m_cnt, m_s1, m_s2, m_prev, m_sign;
    int m_valid, m_rsign, m_mag, m_ovr, m_tmo;
    int az_e;
    bit m_fall;

    function automatic int ab_of(input int s);
        case (s)
            2: return 2;
            3: return 3;
            4: return 0;
            default: return 1;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_sign = 0;
            m_valid = 0; m_rsign = 0; m_mag = 0; m_ovr = 0; m_tmo = 0;
        end else begin
            m_valid = 0;
            m_tmo   = 0;
            m_fall  = (m_prev == 1) && (m_s2 == 0);
            az_e    = (az_len == 0) ? int'(int_len) : int'(az_len);
            case (m_st)
                0: if (start || cont) begin m_st = 1; m_cnt = 0; end else m_cnt++;
                1: if (m_cnt == az_e - 1) begin m_st = 2; m_cnt = 0; end else m_cnt++;
                2: if (m_cnt == int'(int_len) - 1) begin
                       m_sign = m_s2; m_st = 3; m_cnt = 0;
                   end else m_cnt++;
                3: if (m_fall) begin
                       m_mag = m_cnt; m_ovr = 0; m_rsign = m_sign; m_valid = 1; m_st = 4; m_cnt = 0;
                   end else if (m_cnt == int'(dmax) - 1) begin
                       m_mag = int'(dmax); m_ovr = 1; m_rsign = m_sign; m_valid = 1; m_st = 4; m_cnt = 0;
                   end else m_cnt++;
                default: if (m_s2 == 1) begin m_st = 0; m_cnt = 0; end
                   else if (m_cnt == int'(izmax) - 1) begin m_tmo = 1; m_st = 0; m_cnt = 0; end
                   else m_cnt++;
            endcase
            m_prev = m_s2;
            m_s2   = m_s1;
            m_s1   = int'(cmp);
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(ab_o) == ab_of(m_st), "R1 phase code vs model", int'(ab_o), ab_of(m_st));
            chk(int'(res_valid_o) == m_valid, "R5 valid vs model", int'(res_valid_o), m_valid);
            chk(int'(res_mag_o) == m_mag, "R5 magnitude vs model", int'(res_mag_o), m_mag);
            chk(int'(res_sign_o) == m_rsign, "R4 sign vs model", int'(res_sign_o), m_rsign);
            chk(int'(res_ovr_o) == m_ovr, "R6 overrange vs model", int'(res_ovr_o), m_ovr);
            chk(int'(iz_tmo_o) == m_tmo, "R8 timeout flag vs model", int'(iz_tmo_o), m_tmo);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            finish_run();
        end
    end

    task automatic wait_ab(input logic [1:0] code, output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (ab_o != code && n < 5000);
    endtask

    task automatic wait_valid();
        int n = 0;
        do begin @(negedge clk); n++; end while (!res_valid_o && n < 5000);
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    int n;

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset values
        chk(ab_o == 2'b01, "R11 reset phase", int'(ab_o), 1);
        chk(!res_valid_o && !res_sign_o && !res_ovr_o && !iz_tmo_o, "R11 reset flags", 1, 0);
        chk(res_mag_o == 0, "R11 reset magnitude", int'(res_mag_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // A: positive input, comparator toggled through auto-zero (R9)
        cmp = 1'b1;
        pulse_start();
        n = 0;
        do begin @(negedge clk); n++; cmp = ~cmp; end while (ab_o != 2'b10 && n < 5000);
        chk(n == 4, "R3 auto-zero length R9 toggling ignored", n, 4);
        cmp = 1'b1;
        wait_ab(2'b11, n);
        chk(n == 8, "R2 integration length", n, 8);
        repeat (3) @(negedge clk);
        cmp = 1'b0;
        wait_valid();
        chk(res_mag_o == 5, "R5 magnitude with sync delay", int'(res_mag_o), 5);
        chk(res_sign_o == 1'b1, "R4 positive sign", int'(res_sign_o), 1);
        chk(res_ovr_o == 1'b0, "R5 no overrange", int'(res_ovr_o), 0);
        repeat (3) @(negedge clk);
        chk(ab_o == 2'b00, "R7 zero phase held while comparator low", int'(ab_o), 0);
        cmp = 1'b1;
        wait_ab(2'b01, n);
        chk(n == 3, "R7 leave zero phase after comparator high", n, 3);

        // B: negative input, auto-zero length from integration length (R3)
        az_len = 16'd0; int_len = 16'd6; cmp = 1'b0;
        repeat (2) @(negedge clk);
        pulse_start();
        wait_ab(2'b10, n);
        chk(n == 6, "R3 zero auto-zero length uses integration length", n, 6);
        wait_ab(2'b11, n);
        cmp = 1'b1;
        repeat (4) @(negedge clk);
        cmp = 1'b0;
        wait_valid();
        chk(res_mag_o == 6, "R5 magnitude negative case", int'(res_mag_o), 6);
        chk(res_sign_o == 1'b0, "R4 negative sign", int'(res_sign_o), 0);
        cmp = 1'b1;
        wait_ab(2'b01, n);

        // C: de-integration timeout, start pulses ignored while busy (R10)
        az_len = 16'd3; int_len = 16'd7; dmax = 16'd10; cmp = 1'b1;
        pulse_start();
        wait_ab(2'b10, n);
        pulse_start();
        wait_ab(2'b11, n);
        chk(n == 6, "R10 start ignored during integration", n, 6);
        wait_valid();
        chk(res_ovr_o == 1'b1, "R6 overrange flag", int'(res_ovr_o), 1);
        chk(res_mag_o == 10, "R6 magnitude at limit", int'(res_mag_o), 10);
        @(negedge clk);
        chk(ab_o == 2'b01, "R7 immediate exit with comparator high", int'(ab_o), 1);

        // D: integrator-zero timeout
        dmax = 16'd100; izmax = 16'd5;
        pulse_start();
        wait_ab(2'b11, n);
        repeat (2) @(negedge clk);
        cmp = 1'b0;
        wait_valid();
        chk(res_mag_o == 4, "R5 magnitude short ramp", int'(res_mag_o), 4);
        n = 0;
        do begin @(negedge clk); n++; end while (!iz_tmo_o && n < 5000);
        chk(n == 5, "R8 timeout after limit", n, 5);
        chk(ab_o == 2'b01, "R8 auto-zero after timeout", int'(ab_o), 1);
        repeat (3) @(negedge clk);
        chk(ab_o == 2'b01, "R10 stays idle without request", int'(ab_o), 1);

        // E: continuous mode, two back-to-back conversions
        az_len = 16'd0; int_len = 16'd5; izmax = 16'd50; cont = 1'b1;
        for (int k = 0; k < 2; k++) begin
            wait_ab(2'b10, n);
            cmp = 1'b1;
            wait_ab(2'b11, n);
            repeat (2) @(negedge clk);
            cmp = 1'b0;
            wait_valid();
            chk(res_mag_o == 4, "R10 continuous conversion magnitude", int'(res_mag_o), 4);
            cmp = 1'b1;
        end
        cont = 1'b0;
        wait_ab(2'b01, n);
        repeat (20) @(negedge clk);
        chk(ab_o == 2'b01, "R10 idle after continuous dropped", int'(ab_o), 1);
        finish_run();
    end
endmodule